// File: doc/BRIEF.md
# SPI NOR Command Shifter

This block runs one single-bit SPI transaction to a serial NOR flash from a small set of byte registers. Software loads up to six program bytes and a bit count, and writes a command code. The engine then lowers chip select and clocks out a 48-bit frame. The opcode sits in the highest slot and goes out first. The engine samples MISO into six capture bytes laid out on the same 48-bit frame. The reply to an opcode followed by N transmit bytes therefore starts in capture slot 4−N and continues into lower slots. Any transmit slot that software does not use must be loaded with zero. The receive phase is simply the tail of the frame.

Two shortcut codes need no program bytes. One reads the flash status byte into a dedicated status register. The other writes a status byte taken from the top program slot. The serial clock is the system clock divided by a programmable half-period.

Software starts an operation by writing the command register. While the operation runs, the command register reads back its low five bits. It reads zero once the transaction completes, and the `busy` output mirrors the same condition.

Top module: `nor_cmd_shifter`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `busy` is 0, and the command, count and capture registers read 0.
- R2: Command code 0x04 shifts exactly `count` bits, MSB first. Bit k (k = 0 first) sent on MOSI is bit 47−k of the frame made of program slot 5 (bits 47..40) down to slot 0 (bits 7..0).
- R3: For code 0x04, the MISO value sampled at the k-th rising clock edge lands in bit 47−k of the capture frame. Capture slot n holds bits 8n+7..8n. Frame bits beyond `count` read as 0.
- R4: The bus runs in SPI mode 0. The clock idles low. Chip select stays low across every clock pulse. MOSI does not change while the clock is high.
- R5: Each clock high phase and each low phase lasts (div+1) system clocks, where div is the value in the divider register.
- R6: While a command runs, `busy` is 1 and the command register reads the code's low five bits. After completion it reads 0.
- R7: A command write that arrives while `busy` is 1 is ignored, and the running transaction finishes unchanged.
- R8: Code 0x04 with a count of 0 or above 48 completes without lowering chip select or pulsing the clock, and the capture registers keep their values.
- R9: Code 0x02 sends the read-status opcode 0x05 followed by 8 more clocks, 16 in total. The second byte received is stored in the status register, and the capture registers are left unchanged.
- R10: Code 0x20 sends the write-status opcode 0x01 followed by program slot 5, 16 clocks in total, and leaves the status register unchanged.
- R11: A write of any other command code is ignored: `busy` stays 0 and no clock pulse occurs.

Register map (8-bit data): 0x00 command, 0x01 bit count, 0x02 status, 0x03 clock divider, 0x08+n program slot n, 0x10+n capture slot n (n = 0..5). Writes to the divider are ignored while busy. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on address) |
| busy | output | 1 | Transaction in progress |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to flash |
| spiMiso | input | 1 | Serial data from flash |

## Verification
Assertions check the pin discipline on every cycle. The clock only pulses inside chip select, and MOSI holds while the clock is high. The pins are quiet when idle. The latched command holds during a transfer, the bit index stays within the loaded length, and the capture and status registers change only when a transfer owns them. The bench scenarios cover what no single-cycle property can show. These are the exact bit order on MOSI, where each MISO bit lands in the capture frame, and the clock half-period for each divider value. The bench also covers the rejection of bad counts, commands written while busy and unknown codes. It sweeps every count from 0 to 49 at two divider settings.

// File: rtl/nor_shift_pkg.sv
package nor_shift_pkg;
  localparam int FRAME_BYTES = 6;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BITS  = FRAME_BYTES * BYTE_W;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int ADDR_W      = 5;

  localparam logic [ADDR_W-1:0] ADDR_CMD    = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 5'h02;
  localparam logic [ADDR_W-1:0] ADDR_DIV    = 5'h03;
  localparam logic [ADDR_W-1:0] ADDR_SLOT0  = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_CAP0   = 5'h10;

  localparam logic [7:0] CODE_PROG = 8'h04;
  localparam logic [7:0] CODE_RDSR = 8'h02;
  localparam logic [7:0] CODE_WRSR = 8'h20;

  typedef enum logic [1:0] {
    KIND_PROG = 2'd0,
    KIND_RDSR = 2'd1,
    KIND_WRSR = 2'd2
  } xferKind_e;

  typedef struct packed {
    logic             active;
    logic             load;
    logic             sample;
    xferKind_e        kind;
    logic [IDX_W-1:0] bitIdx;
  } shiftStrobe_t;
endpackage

// File: rtl/nor_shift_ctrl.sv
module nor_shift_ctrl
  import nor_shift_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              busy,
  output logic [7:0]        ctrlRdata,
  output shiftStrobe_t      strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_TRAIL, ST_FIN
  } state_e;

  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(2 * BYTE_W - 1);
  localparam logic [7:0]       MAX_COUNT  = 8'(FRAME_BITS);

  state_e           state;
  logic [7:0]       cmdReg;
  logic [7:0]       countReg;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] halfCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  xferKind_e        kindReg;
  xferKind_e        newKind;
  logic             cmdWr, codeKnown, progLenOk, startXfer, startEmpty, halfDone;

  always_comb begin
    cmdWr     = regWe && (regAddr == ADDR_CMD) && (state == ST_IDLE);
    newKind   = KIND_PROG;
    codeKnown = 1'b1;
    case (regWdata)
      CODE_PROG: newKind = KIND_PROG;
      CODE_RDSR: newKind = KIND_RDSR;
      CODE_WRSR: newKind = KIND_WRSR;
      default:   codeKnown = 1'b0;
    endcase
    progLenOk  = (countReg != 8'd0) && (countReg <= MAX_COUNT);
    startXfer  = cmdWr && codeKnown && ((newKind != KIND_PROG) || progLenOk);
    startEmpty = cmdWr && codeKnown && (newKind == KIND_PROG) && !progLenOk;
    halfDone   = (halfCnt == divReg);
    busy       = (state != ST_IDLE);
  end

  always_comb begin
    strobe.active = !spiCsN;
    strobe.load   = startXfer;
    strobe.sample = (state == ST_LOW) && halfDone;
    strobe.kind   = startXfer ? newKind : kindReg;
    strobe.bitIdx = bitIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cmdReg   <= '0;
      countReg <= '0;
      divReg   <= '0;
      halfCnt  <= '0;
      bitIdx   <= '0;
      lastIdx  <= '0;
      kindReg  <= KIND_PROG;
      spiSclk  <= 1'b0;
      spiCsN   <= 1'b1;
    end else begin
      if (regWe && regAddr == ADDR_COUNT) countReg <= regWdata;
      if (regWe && regAddr == ADDR_DIV && state == ST_IDLE) divReg <= DIV_W'(regWdata);
      case (state)
        ST_IDLE: begin
          if (startXfer) begin
            cmdReg  <= regWdata;
            kindReg <= newKind;
            lastIdx <= (newKind == KIND_PROG) ? IDX_W'(countReg - 8'd1) : SHORT_LAST;
            bitIdx  <= '0;
            halfCnt <= '0;
            spiCsN  <= 1'b0;
            state   <= ST_LOW;
          end else if (startEmpty) begin
            cmdReg <= regWdata;
            state  <= ST_FIN;
          end
        end
        ST_LOW: begin
          if (halfDone) begin
            halfCnt <= '0;
            spiSclk <= 1'b1;
            state   <= ST_HIGH;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (halfDone) begin
            halfCnt <= '0;
            spiSclk <= 1'b0;
            if (bitIdx == lastIdx) begin
              state <= ST_TRAIL;
            end else begin
              bitIdx <= bitIdx + 1'b1;
              state  <= ST_LOW;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_TRAIL: begin
          if (halfDone) begin
            halfCnt <= '0;
            spiCsN  <= 1'b1;
            state   <= ST_FIN;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_FIN: begin
          cmdReg <= '0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlRdata = '0;
    case (regAddr)
      ADDR_CMD:   ctrlRdata = busy ? {3'b000, cmdReg[4:0]} : 8'h00;
      ADDR_COUNT: ctrlRdata = countReg;
      ADDR_DIV:   ctrlRdata = 8'(divReg);
      default:    ctrlRdata = '0;
    endcase
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> !spiCsN) else $error("sclk high outside chip select"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (spiCsN && !spiSclk)) else $error("pins active while idle"); // R8
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW || state == ST_HIGH || state == ST_TRAIL) |=> (cmdReg == $past(cmdReg)))
    else $error("command changed mid transfer"); // R7
  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> (bitIdx <= lastIdx)) else $error("bit index past length"); // R2
  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfCnt <= divReg)) else $error("half period counter overran"); // R5
endmodule

// File: rtl/nor_shift_dp.sv
module nor_shift_dp
  import nor_shift_pkg::*;
#(
  parameter logic [7:0] RDSR_OP = 8'h05,
  parameter logic [7:0] WRSR_OP = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  shiftStrobe_t      strobe,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic [7:0]        dpRdata
);
  localparam int BIT_SEL_W = $clog2(BYTE_W);

  logic [FRAME_BYTES-1:0][BYTE_W-1:0] slotReg;
  logic [FRAME_BITS-1:0]              frameReg;
  logic [FRAME_BITS-1:0]              capReg;
  logic [BYTE_W-1:0]                  statusReg;
  logic [IDX_W-1:0]                   posIdx;
  logic [IDX_W-1:0]                   stIdx;
  logic [FRAME_BYTES-1:0]             slotHit;
  logic [FRAME_BYTES-1:0]             capHit;

  assign posIdx = IDX_W'(FRAME_BITS - 1) - strobe.bitIdx;
  assign stIdx  = IDX_W'(2 * BYTE_W - 1) - strobe.bitIdx;

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_dec
    assign slotHit[g] = (regAddr == ADDR_W'(ADDR_SLOT0 + g));
    assign capHit[g]  = (regAddr == ADDR_W'(ADDR_CAP0 + g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotReg <= '0;
    end else if (regWe) begin
      for (int i = 0; i < FRAME_BYTES; i++) begin
        if (slotHit[i]) slotReg[i] <= regWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg  <= '0;
      capReg    <= '0;
      statusReg <= '0;
    end else if (strobe.load) begin
      case (strobe.kind)
        KIND_RDSR: frameReg <= {RDSR_OP, {(FRAME_BITS - BYTE_W){1'b0}}};
        KIND_WRSR: frameReg <= {WRSR_OP, slotReg[FRAME_BYTES-1], {(FRAME_BITS - 2*BYTE_W){1'b0}}};
        default: begin
          frameReg <= slotReg;
          capReg   <= '0;
        end
      endcase
    end else if (strobe.sample) begin
      if (strobe.kind == KIND_PROG) begin
        capReg[posIdx] <= spiMiso;
      end else if (strobe.kind == KIND_RDSR && strobe.bitIdx >= IDX_W'(BYTE_W)) begin
        statusReg[stIdx[BIT_SEL_W-1:0]] <= spiMiso;
      end
    end
  end

  assign spiMosi = strobe.active & frameReg[posIdx];

  always_comb begin
    dpRdata = '0;
    if (regAddr == ADDR_STATUS) dpRdata = statusReg;
    for (int i = 0; i < FRAME_BYTES; i++) begin
      if (slotHit[i]) dpRdata = slotReg[i];
      if (capHit[i])  dpRdata = capReg[i*BYTE_W +: BYTE_W];
    end
  end

  AST_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.active && !strobe.load) |=> $stable(capReg)) else $error("capture moved while idle"); // R3
  AST_STATUS_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.kind != KIND_RDSR) |=> $stable(statusReg)) else $error("status moved outside read-status"); // R9
endmodule

// File: rtl/nor_cmd_shifter.sv
module nor_cmd_shifter
  import nor_shift_pkg::*;
#(
  parameter int         DIV_W   = 8,
  parameter logic [7:0] RDSR_OP = 8'h05,
  parameter logic [7:0] WRSR_OP = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              busy,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);
  shiftStrobe_t strobe;
  logic [7:0]   ctrlRdata;
  logic [7:0]   dpRdata;

  nor_shift_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .busy(busy), .ctrlRdata(ctrlRdata), .strobe(strobe)
  );

  nor_shift_dp #(.RDSR_OP(RDSR_OP), .WRSR_OP(WRSR_OP)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .strobe(strobe), .spiMiso(spiMiso), .spiMosi(spiMosi), .dpRdata(dpRdata)
  );

  assign regRdata = ctrlRdata | dpRdata;

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi)) else $error("mosi moved with clock high"); // R4
endmodule

// File: tb/nor_cmd_shifter_tb.sv
module nor_cmd_shifter_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       busy, spiCsN, spiSclk, spiMosi, spiMiso;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int edgeTotal = 0, edgeBase = 0;
  int hiTotal = 0, csTotal = 0;
  logic [47:0] rec = '0;
  logic [47:0] resp = '0;

  always #4 clk = ~clk;

  nor_cmd_shifter u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .busy(busy), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // flash model: reply bit k is driven until the k-th rising edge
  assign spiMiso = ((edgeTotal - edgeBase) < 48) ? resp[47 - (edgeTotal - edgeBase)] : 1'b0;

  always @(posedge spiSclk) begin
    if ((edgeTotal - edgeBase) < 48) rec[47 - (edgeTotal - edgeBase)] = spiMosi;
    edgeTotal = edgeTotal + 1;
  end
  always @(posedge clk) if (spiSclk) hiTotal = hiTotal + 1;
  always @(negedge spiCsN) csTotal = csTotal + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic readCaps(output logic [47:0] c);
    logic [7:0] b;
    for (int i = 0; i < 6; i++) begin
      regRead(5'(16 + i), b);
      c[i*8 +: 8] = b;
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [47:0] topMask(input int n);
    logic [47:0] m = '0;
    for (int i = 0; i < n && i < 48; i++) m[47 - i] = 1'b1;
    return m;
  endfunction

  function automatic logic [47:0] lfsr(input logic [47:0] x);
    return {x[46:0], x[47] ^ x[46] ^ x[20] ^ x[19]};
  endfunction

  task automatic runProg(input int cnt, input int dv, input logic [47:0] slots, input logic [47:0] rsp);
    logic [47:0] prevCap, capNow, mask;
    logic [7:0]  rd;
    int hi0, cs0;
    for (int i = 0; i < 6; i++) regWrite(5'(8 + i), slots[i*8 +: 8]);
    regWrite(5'h01, 8'(cnt));
    regWrite(5'h03, 8'(dv));
    readCaps(prevCap);
    resp = rsp; edgeBase = edgeTotal; hi0 = hiTotal; cs0 = csTotal;
    regWrite(5'h00, 8'h04);
    regRead(5'h00, rd);
    chk(rd == 8'h04 && busy, "R6 busy readback", {rd, 7'd0, busy}, {8'h04, 8'h01});
    waitIdle();
    regRead(5'h00, rd);
    chk(rd == 8'h00, "R6 clear on completion", rd, 0);
    mask = topMask(cnt);
    readCaps(capNow);
    if (cnt >= 1 && cnt <= 48) begin
      chk((rec & mask) == (slots & mask), "R2 mosi frame", rec & mask, slots & mask);
      chk(edgeTotal - edgeBase == cnt, "R2 clock count", edgeTotal - edgeBase, cnt);
      chk(hiTotal - hi0 == cnt * (dv + 1), "R5 high phase length", hiTotal - hi0, cnt * (dv + 1));
      chk(capNow == (rsp & mask), "R3 capture frame", capNow, rsp & mask);
    end else begin
      chk(edgeTotal == edgeBase && csTotal == cs0, "R8 no bus activity", edgeTotal - edgeBase, 0);
      chk(capNow == prevCap, "R8 capture kept", capNow, prevCap);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rd, st;
    logic [47:0] seed, caps0, caps1;
    int hi0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(spiCsN && !spiSclk && !busy, "R1 pins", {spiCsN, spiSclk, busy}, 3'b100);
    regRead(5'h00, rd); chk(rd == 0, "R1 command", rd, 0);
    regRead(5'h01, rd); chk(rd == 0, "R1 count", rd, 0);
    readCaps(caps0);    chk(caps0 == 0, "R1 capture", caps0, 0);

    // R2 R3 R5 R6 R8 count sweep at two dividers
    seed = 48'hC0FFEE_123457;
    for (int dv = 0; dv <= 2; dv += 2) begin
      for (int cnt = 0; cnt <= 49; cnt++) begin
        logic [47:0] s, r;
        seed = lfsr(seed); s = seed;
        seed = lfsr(seed); r = seed;
        runProg(cnt, dv, s, r);
      end
    end

    // R9 read status
    regWrite(5'h03, 8'd1);
    readCaps(caps0);
    resp = 48'h5A_C3_00_00_00_00; edgeBase = edgeTotal;
    regWrite(5'h00, 8'h02);
    regRead(5'h00, rd);
    chk(rd == 8'h02 && busy, "R6 read-status busy", rd, 8'h02);
    waitIdle();
    chk(rec[47:32] == 16'h0500, "R9 opcode sent", rec[47:32], 16'h0500);
    chk(edgeTotal - edgeBase == 16, "R9 clock count", edgeTotal - edgeBase, 16);
    regRead(5'h02, st);
    chk(st == 8'hC3, "R9 status captured", st, 8'hC3);
    readCaps(caps1);
    chk(caps1 == caps0, "R9 capture untouched", caps1, caps0);

    // R10 write status
    regWrite(5'h0D, 8'hA7);
    edgeBase = edgeTotal; resp = 48'hFF_FF_00_00_00_00;
    regWrite(5'h00, 8'h20);
    chk(busy == 1'b1, "R10 busy", busy, 1);
    waitIdle();
    chk(rec[47:32] == 16'h01A7, "R10 frame sent", rec[47:32], 16'h01A7);
    chk(edgeTotal - edgeBase == 16, "R10 clock count", edgeTotal - edgeBase, 16);
    regRead(5'h02, rd);
    chk(rd == st, "R10 status unchanged", rd, st);

    // R7 command while busy ignored
    for (int i = 0; i < 6; i++) regWrite(5'(8 + i), 8'(8'h11 * (i + 1)));
    regWrite(5'h01, 8'd48);
    regWrite(5'h03, 8'd2);
    resp = 48'h0123_4567_89AB; edgeBase = edgeTotal; hi0 = hiTotal;
    regWrite(5'h00, 8'h04);
    repeat (10) @(negedge clk);
    regWrite(5'h00, 8'h02);
    regRead(5'h00, rd);
    chk(rd == 8'h04, "R7 command held", rd, 8'h04);
    waitIdle();
    chk(edgeTotal - edgeBase == 48, "R7 full length kept", edgeTotal - edgeBase, 48);
    readCaps(caps1);
    chk(caps1 == 48'h0123_4567_89AB, "R7 capture intact", caps1, 48'h0123_4567_89AB);
    regRead(5'h02, rd);
    chk(rd == st, "R7 status not rewritten", rd, st);

    // R11 unknown code
    edgeBase = edgeTotal;
    regWrite(5'h00, 8'h81);
    chk(!busy, "R11 not busy", busy, 0);
    repeat (5) @(negedge clk);
    chk(edgeTotal == edgeBase && spiCsN, "R11 no activity", edgeTotal - edgeBase, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule